// File: doc/BRIEF.md
# Interrupt Vector Mapper with Pending Retry

This unit sits between a set of interrupt sources and one CPU core. Each cycle a source presents a code on `req_code`, and any non-zero code is a request. With translation on, the unit looks the code up in an eight-slot programmable table of (code, vector) pairs. With translation off, the code itself serves as the vector. The resulting vector is held in a single pending register. It is offered to the core on every cycle until the core acknowledges it.

A second request can arrive while a vector is still pending. If it names the same vector it is dropped. If it names a different vector, a policy input decides what happens: flag an error, overwrite the pending vector with the new one, or overwrite it with a fixed collision vector. Unsupported codes and error-policy collisions set a sticky error flag, which stays set until software pulses a clear. A request that errors never alters the pending vector.

Top module: `irq_vec_unit`

## Requirements
- R1: A zero `req_code` is no request: it changes neither the pending vector nor the error flag.
- R2: With `xlate_en`=1, a non-zero code that matches a valid table slot makes that slot's vector pending (when nothing is pending). If several slots match, the lowest index wins.
- R3: With `xlate_en`=1, a non-zero code with no matching valid slot, or whose slot holds vector 0, sets the error flag and leaves the pending vector unchanged.
- R4: With `xlate_en`=0, a non-zero code below 2^VEC_W becomes the vector unchanged. A code of 2^VEC_W or above sets the error flag and leaves the pending vector unchanged.
- R5: A request whose vector equals the pending vector is dropped without error.
- R6: With `policy`=0 or 3, a request for a different vector while one is pending sets the error flag and keeps the old vector.
- R7: With `policy`=1, a different vector replaces the pending one.
- R8: With `policy`=2, a collision makes `collide_vec` pending. If `collide_vec` is 0, the collision is treated as an error instead.
- R9: `irq_valid` is 1 exactly when the pending vector is non-zero, and `irq_vector` shows it. The pending vector stays offered until `irq_ack` is sampled high, after which it is 0 on the next cycle.
- R10: An `irq_ack` and a new request in the same cycle act as if the clear came first: the new vector becomes pending with no collision.
- R11: The error flag is sticky until `err_clr` is sampled high. A new error in the same cycle as `err_clr` leaves the flag set.
- R12: A table write with `tbl_code`=0 is ignored. A lookup in the same cycle as a write uses the table contents from before the write.
- R13: After reset, all table slots are invalid, nothing is pending and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | 1: translate through the table, 0: pass the code through |
| policy | input | 2 | Collision policy: 0 error, 1 replace, 2 substitute, 3 error |
| collide_vec | input | VEC_W | Fixed vector used by the substitute policy |
| tbl_we | input | 1 | Table slot write strobe |
| tbl_idx | input | IDX_W | Slot index to write |
| tbl_code | input | CODE_W | Code stored in the slot (0 ignores the write) |
| tbl_vec | input | VEC_W | Vector stored in the slot |
| tbl_valid | input | 1 | Valid bit stored in the slot |
| req_code | input | CODE_W | Interrupt code, 0 means no request |
| irq_valid | output | 1 | A vector is pending |
| irq_vector | output | VEC_W | Pending vector, 0 when none |
| irq_ack | input | 1 | Core accepts the pending vector |
| err_flag | output | 1 | Sticky error flag |
| err_clr | input | 1 | Clears the error flag |

## Verification
The properties assume that `irq_ack` is honoured whether or not a vector is pending. They also assume that the policy and collision vector may change on any cycle, so none of them depends on configuration staying stable. The properties that predict the next pending value limit themselves to cycles where the outcome follows from the ports alone: passthrough codes that fit, zero codes, or no request at all. The random stimulus draws codes from a small pool made of table codes, unmapped codes and zero, so hits, misses and collisions all occur often. It switches translation, policy and collision vector freely. It also rewrites table slots now and then, including with zero codes, so that writes happen in the same cycle as lookups.

// File: rtl/irq_vec_unit.sv
module irq_vec_unit #(
  parameter int CODE_W  = 16,
  parameter int VEC_W   = 8,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic [1:0]        policy,
  input  logic [VEC_W-1:0]  collide_vec,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [CODE_W-1:0] tbl_code,
  input  logic [VEC_W-1:0]  tbl_vec,
  input  logic              tbl_valid,
  input  logic [CODE_W-1:0] req_code,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack,
  output logic              err_flag,
  input  logic              err_clr
);
  localparam logic [1:0] POL_REPLACE = 2'd1;
  localparam logic [1:0] POL_SUBST   = 2'd2;

  logic [ENTRIES-1:0] slot_ok;
  logic [CODE_W-1:0]  slot_code [ENTRIES];
  logic [VEC_W-1:0]   slot_vec  [ENTRIES];
  logic [ENTRIES-1:0] slot_hit;

  logic [VEC_W-1:0] pend_q, pend_eff, pend_d;
  logic             hit;
  logic [VEC_W-1:0] hit_vec, req_vec;
  logic             fits, unsup, err_now;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_ok[g]   <= 1'b0;
        slot_code[g] <= '0;
        slot_vec[g]  <= '0;
      end else if (tbl_we && tbl_idx == IDX_W'(g) && tbl_code != '0) begin
        slot_ok[g]   <= tbl_valid;
        slot_code[g] <= tbl_code;
        slot_vec[g]  <= tbl_vec;
      end
    end
    assign slot_hit[g] = slot_ok[g] && slot_code[g] == req_code;
  end

  always_comb begin
    hit     = 1'b0;
    hit_vec = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        hit     = 1'b1;
        hit_vec = slot_vec[i];
      end
    end
  end

  assign fits    = (req_code >> VEC_W) == '0;
  assign req_vec = xlate_en ? hit_vec : req_code[VEC_W-1:0];
  assign unsup   = xlate_en ? (!hit || hit_vec == '0) : !fits;
  assign pend_eff = irq_ack ? '0 : pend_q;

  always_comb begin
    pend_d  = pend_eff;
    err_now = 1'b0;
    if (req_code != '0) begin
      if (unsup)
        err_now = 1'b1;
      else if (pend_eff == '0)
        pend_d = req_vec;
      else if (req_vec != pend_eff) begin
        if (policy == POL_REPLACE)
          pend_d = req_vec;
        else if (policy == POL_SUBST && collide_vec != '0)
          pend_d = collide_vec;
        else
          err_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      err_flag <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      err_flag <= err_now | (err_flag & ~err_clr);
    end
  end

  assign irq_vector = pend_q;
  assign irq_valid  = pend_q != '0;
endmodule

// File: rtl/irq_vec_unit_chk.sv
module irq_vec_unit_chk #(
  parameter int CODE_W  = 16,
  parameter int VEC_W   = 8,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlate_en,
  input logic [CODE_W-1:0] req_code,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              irq_ack,
  input logic              err_flag,
  input logic              err_clr
);
  a_r1_idle_keeps_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == '0 && !irq_ack) |=> $stable(irq_vector));

  a_r1_idle_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == '0 && !err_flag) |=> !err_flag);

  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlate_en && req_code != '0 && (req_code >> VEC_W) == '0 && (!irq_valid || irq_ack))
      |=> irq_vector == $past(req_code[VEC_W-1:0]));

  a_r9_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> irq_valid);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && req_code == '0) |=> !irq_valid);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && req_code == '0) |=> !err_flag);
endmodule

bind irq_vec_unit irq_vec_unit_chk #(.CODE_W(CODE_W), .VEC_W(VEC_W), .ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .req_code(req_code),
  .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack),
  .err_flag(err_flag), .err_clr(err_clr));

// File: tb/irq_vec_unit_tb_top.sv
module irq_vec_unit_tb_top;
  localparam int CW = 16, VW = 8, N = 8, IW = 3;

  logic clk = 0, rst_n = 0;
  logic xlate_en = 0;
  logic [1:0] policy = 0;
  logic [VW-1:0] collide_vec = 0;
  logic tbl_we = 0, tbl_valid = 0;
  logic [IW-1:0] tbl_idx = 0;
  logic [CW-1:0] tbl_code = 0;
  logic [VW-1:0] tbl_vec = 0;
  logic [CW-1:0] req_code = 0;
  logic irq_valid, irq_ack = 0, err_flag, err_clr = 0;
  logic [VW-1:0] irq_vector;

  irq_vec_unit dut_i (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic          m_ok   [N];
  logic [CW-1:0] m_code [N];
  logic [VW-1:0] m_vec  [N];
  logic [VW-1:0] m_pend = 0;
  logic          m_err = 0;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_ok[i] = 0; m_code[i] = 0; m_vec[i] = 0; end
    m_pend = 0; m_err = 0;
  endtask

  task automatic model_step();
    logic hit = 0, bad, nerr = 0;
    logic [VW-1:0] v = 0, pe, np;
    if (xlate_en) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_ok[i] && m_code[i] == req_code) begin hit = 1; v = m_vec[i]; end
      bad = !hit || v == 0;
    end else begin
      bad = req_code > CW'((1 << VW) - 1);
      v = req_code[VW-1:0];
    end
    pe = irq_ack ? '0 : m_pend;
    np = pe;
    if (req_code != 0) begin
      if (bad) nerr = 1;
      else if (pe == 0) np = v;
      else if (v != pe) begin
        if (policy == 1) np = v;
        else if (policy == 2 && collide_vec != 0) np = collide_vec;
        else nerr = 1;
      end
    end
    m_err = nerr ? 1'b1 : (err_clr ? 1'b0 : m_err);
    m_pend = np;
    if (tbl_we && tbl_code != 0) begin
      m_ok[tbl_idx] = tbl_valid; m_code[tbl_idx] = tbl_code; m_vec[tbl_idx] = tbl_vec;
    end
  endtask

  task automatic check(string tag);
    n_chk++;
    if (irq_valid !== (m_pend != 0) || irq_vector !== m_pend || err_flag !== m_err) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b vec=%0d err=%0b, expected valid=%0b vec=%0d err=%0b",
               tag, irq_valid, irq_vector, err_flag, m_pend != 0, m_pend, m_err);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    tbl_we = 0; req_code = 0; irq_ack = 0; err_clr = 0;
    check(tag);
  endtask

  task automatic wr(int idx, int code, int vec, bit vld);
    tbl_we = 1; tbl_idx = IW'(idx); tbl_code = CW'(code); tbl_vec = VW'(vec); tbl_valid = vld;
    step("R12 table write");
  endtask

  task automatic req(int code, string tag);
    req_code = CW'(code);
    step(tag);
  endtask

  task automatic ack_clr(string tag);
    irq_ack = 1; err_clr = 1;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  int unsigned seed_dummy;
  initial begin
    seed_dummy = $urandom(32'd4711);
    model_reset();
    step("R13 reset");
    step("R13 reset");
    rst_n = 1;
    @(negedge clk);
    check("R13 after reset");

    xlate_en = 1;
    wr(0, 16'h0100, 8'h21, 1);
    wr(1, 16'h0200, 8'h22, 1);
    wr(2, 16'h0100, 8'h33, 1);
    wr(3, 16'h0300, 8'h00, 1);
    wr(4, 16'h0000, 8'h44, 1);
    req(16'h0200, "R2 table hit");
    req(0, "R1 zero code holds");
    req(16'h0200, "R5 same vector dropped");
    ack_clr("R9 ack clears");
    req(16'h0100, "R2 lowest index wins");
    ack_clr("R9 ack clears");
    req(16'h0500, "R3 no match error");
    req(16'h0300, "R3 zero vector slot error");
    ack_clr("R11 clear");
    req(0, "R1 nothing after clear");

    req(16'h0100, "R2 hit");
    policy = 0; req(16'h0200, "R6 error policy collision");
    policy = 3; req(16'h0200, "R6 policy 3 collision");
    err_clr = 1; req(16'h0200, "R11 set wins over clear");
    policy = 1; req(16'h0200, "R7 replace");
    policy = 2; collide_vec = 8'h7F; req(16'h0100, "R8 substitute");
    collide_vec = 0; req(16'h0200, "R8 zero collide vector errors");
    ack_clr("R9 ack");
    req(16'h0100, "R2 hit");
    policy = 0; irq_ack = 1; req(16'h0200, "R10 ack with new request");

    ack_clr("R9 ack");
    tbl_we = 1; tbl_idx = 5; tbl_code = 16'h0600; tbl_vec = 8'h66; tbl_valid = 1;
    req(16'h0600, "R12 same-cycle write not seen");
    ack_clr("R11 clear");
    req(16'h0600, "R12 written slot now hits");
    ack_clr("R9 ack");
    wr(5, 16'h0600, 8'h66, 0);
    req(16'h0600, "R12 invalidated slot misses");
    ack_clr("R11 clear");

    xlate_en = 0;
    req(16'h00A5, "R4 passthrough");
    ack_clr("R9 ack");
    req(16'h0100, "R4 too-wide code error");
    req(16'h00FF, "R4 passthrough max");
    ack_clr("R9 ack");

    for (int k = 0; k < 4000; k++) begin
      int unsigned r = $urandom % 10;
      xlate_en = ($urandom % 4) != 0;
      policy = 2'($urandom);
      collide_vec = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      if (xlate_en)
        req_code = (r < 3) ? 16'h0 : CW'(16'h0100 * (1 + $urandom % 9));
      else
        req_code = (r < 3) ? 16'h0 : CW'($urandom % 300);
      irq_ack = ($urandom % 10) < 3;
      err_clr = ($urandom % 10) == 0;
      if ($urandom % 20 == 0) begin
        tbl_we = 1; tbl_idx = IW'($urandom);
        tbl_code = ($urandom % 4 == 0) ? 16'h0 : CW'(16'h0100 * (1 + $urandom % 9));
        tbl_vec = ($urandom % 6 == 0) ? 8'h0 : 8'($urandom);
        tbl_valid = ($urandom % 5) != 0;
      end
      step("R2/R3/R5/R6/R7/R8/R10 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule